// File: doc/BRIEF.md
# Nested Radix Page-Table Walker

This block turns a guest effective address into a real address by walking a multi-level radix page table. A walk begins from a root table base, an index-width field for the root table, and the total translated size in bits. At each level the walker picks one 8-byte entry, fetches it through a memory read port, and then does one of three things. It stops with a fault, it descends into the next table named by the entry, or it stops at a leaf and forms the output address.

When a walk is flagged as guest mode, every table-entry address is first sent out on a second-stage translation port. Only the address that comes back is used for the memory read. In hypervisor mode the entry address goes straight to memory. A fault on the second-stage port ends the walk with a table-translation cause. Permission checks and reference/change updates are done elsewhere.

Every data path is valid/ready. A request is taken only while `req_ready` is high, and that is the case only when no walk is in flight. The block raises `nt_req_valid`, `mem_req_valid` and `res_valid` and holds each of them, with its payload unchanged, until the matching ready is seen high at a clock edge. The two response inputs (`nt_rsp_valid`, `mem_rsp_valid`) carry no ready: the walker always waits for them, for any number of cycles.

Top module: `radix_nested_walker`

## Requirements
- R1: At each level the entry index is (EA >> (remaining − bits)) masked to its low `bits` bits. The entry address is table base + index × 8.
- R2: In hypervisor mode (`req_guest` = 0) no second-stage request is made, and each entry address goes to `mem_req_addr` unchanged.
- R3: In guest mode every entry address is first presented on `nt_req_addr`. The following memory read uses `nt_rsp_addr`.
- R4: A second-stage response with `nt_rsp_fault` = 1 ends the walk with `res_cause` = 2, `res_addr` = 0 and `res_page_size` = 0, and no memory read follows it.
- R5: Entry layout: bit 63 valid, bit 62 leaf. A non-leaf entry gives the next table base as bits [55:8] (low 8 bits zero) and the next index width in bits [4:0]. Each level subtracts its index width from the remaining size. The walk repeats until a leaf is fetched.
- R6: For a leaf, page size = remaining size after the last level and mask = 2^size − 1. Then `res_addr` = ({entry[55:12], 12'b0} & ~mask) | (EA & mask), with `res_cause` = 0.
- R7: A fetched entry with bit 63 clear ends the walk with `res_cause` = 1.
- R8: A level whose index width is zero, or larger than the remaining size, ends the walk with `res_cause` = 1 and no fetch. This covers the root as well as widths taken from an entry.
- R9: At most MAX_LEVELS (default 4) entries are fetched per walk. A further level ends the walk with `res_cause` = 1.
- R10: While a walk is in flight `req_ready` is low. Once `nt_req_valid`, `mem_req_valid` or `res_valid` is raised, it stays high with a stable payload until accepted.
- R11: Memory and second-stage responses may arrive any number of cycles after their request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_ea | input | 64 | Effective address to translate |
| req_guest | input | 1 | 1 = guest mode, entry fetches are nested-translated |
| req_root_base | input | ADDR_W | Root table base address |
| req_root_bits | input | 5 | Index width of the root table |
| req_tree_size | input | 7 | Total translated size in bits |
| nt_req_valid | output | 1 | Second-stage request valid |
| nt_req_ready | input | 1 | Second-stage request accepted |
| nt_req_addr | output | ADDR_W | Entry address to be translated |
| nt_rsp_valid | input | 1 | Second-stage response strobe |
| nt_rsp_addr | input | ADDR_W | Translated entry address |
| nt_rsp_fault | input | 1 | Second-stage translation failed |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Entry read request accepted |
| mem_req_addr | output | ADDR_W | Entry read address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Fetched table entry |
| res_valid | output | 1 | Walk result valid |
| res_ready | input | 1 | Walk result accepted |
| res_addr | output | ADDR_W | Real address (0 on fault) |
| res_page_size | output | 7 | Page size in bits (0 on fault) |
| res_cause | output | 2 | 0 ok, 1 no valid entry, 2 table translation fault |

## Verification
The bench targets walks of different depths, with leaves at the fourth level and at the second level. It also covers a nested fault partway down, an invalid entry, a zero index width, a root width larger than the tree, and a chain of non-leaf entries that hits the level limit.

A shift computed against the wrong remaining size would fetch from an address no table entry occupies. An off-by-one in the level counter would either make a fifth fetch or stop one level early. A walker that ignored the guest flag would send entry addresses to memory without translating them. Each of these shows up as a fetch address mismatch or as the wrong cause.

Random ready stalls and response latencies of one to three cycles check that request payloads stay stable under back-pressure. They also check that a response arriving late is still consumed correctly.

// File: rtl/radix_walk_pkg.sv
`timescale 1ns/1ps
package radix_walk_pkg;
  localparam int SIZE_W         = 7;
  localparam int ENT_NB_W       = 5;
  localparam int ENT_VALID_BIT  = 63;
  localparam int ENT_LEAF_BIT   = 62;
  localparam int ENT_BASE_LSB   = 8;
  localparam int ENT_RPN_LSB    = 12;
  localparam int ENT_BYTES_LOG2 = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEVEL, ST_NT_REQ, ST_NT_WAIT, ST_MEM_REQ, ST_MEM_WAIT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE        = 2'd0,
    CAUSE_NO_ENTRY    = 2'd1,
    CAUSE_TABLE_XLATE = 2'd2
  } walk_cause_e;
endpackage

// File: rtl/radix_entry_addr.sv
`timescale 1ns/1ps
module radix_entry_addr
  import radix_walk_pkg::*;
#(
  parameter int ADDR_W = 56,
  parameter int EA_W   = 64
) (
  input  logic [EA_W-1:0]     ea,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ENT_NB_W-1:0] nbits,
  input  logic [SIZE_W-1:0]   remain,
  output logic [ADDR_W-1:0]   entry_addr
);
  logic [SIZE_W-1:0] shift;
  logic [EA_W-1:0]   idx_mask;
  logic [EA_W-1:0]   idx;

  always_comb begin
    shift      = remain - SIZE_W'(nbits);
    idx_mask   = (EA_W'(1) << nbits) - EA_W'(1);
    idx        = (ea >> shift) & idx_mask;
    entry_addr = base + ADDR_W'(idx << ENT_BYTES_LOG2);
  end
endmodule

// File: rtl/radix_leaf_merge.sv
`timescale 1ns/1ps
module radix_leaf_merge
  import radix_walk_pkg::*;
#(
  parameter int ADDR_W = 56,
  parameter int EA_W   = 64
) (
  input  logic [63:0]       entry,
  input  logic [EA_W-1:0]   ea,
  input  logic [SIZE_W-1:0] page_size,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] off_mask;
  logic [ADDR_W-1:0] rpn;
  logic              unused_bits;

  always_comb begin
    if (page_size >= SIZE_W'(ADDR_W)) off_mask = '1;
    else off_mask = (ADDR_W'(1) << page_size) - ADDR_W'(1);
    rpn  = {entry[ADDR_W-1:ENT_RPN_LSB], {ENT_RPN_LSB{1'b0}}};
    phys = (rpn & ~off_mask) | (ea[ADDR_W-1:0] & off_mask);
  end

  assign unused_bits = ^{entry[63:ADDR_W], entry[ENT_RPN_LSB-1:0], ea[EA_W-1:ADDR_W]};
endmodule

// File: rtl/radix_nested_walker.sv
`timescale 1ns/1ps
module radix_nested_walker
  import radix_walk_pkg::*;
#(
  parameter int ADDR_W     = 56,
  parameter int MAX_LEVELS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_ea,
  input  logic              req_guest,
  input  logic [ADDR_W-1:0] req_root_base,
  input  logic [4:0]        req_root_bits,
  input  logic [6:0]        req_tree_size,
  output logic              nt_req_valid,
  input  logic              nt_req_ready,
  output logic [ADDR_W-1:0] nt_req_addr,
  input  logic              nt_rsp_valid,
  input  logic [ADDR_W-1:0] nt_rsp_addr,
  input  logic              nt_rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic [6:0]        res_page_size,
  output logic [1:0]        res_cause
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  walk_state_e         st_q;
  walk_cause_e         cause_q;
  logic [63:0]         ea_q;
  logic                guest_q;
  logic [ADDR_W-1:0]   base_q, addr_q, pa_q;
  logic [ENT_NB_W-1:0] nb_q;
  logic [SIZE_W-1:0]   rem_q, psize_q;
  logic [LVL_W-1:0]    lvl_q;

  logic [ADDR_W-1:0]   idx_addr;
  logic [ADDR_W-1:0]   leaf_pa;
  logic                level_bad;

  radix_entry_addr #(.ADDR_W(ADDR_W), .EA_W(64)) u_idx (
    .ea(ea_q), .base(base_q), .nbits(nb_q), .remain(rem_q), .entry_addr(idx_addr)
  );

  radix_leaf_merge #(.ADDR_W(ADDR_W), .EA_W(64)) u_merge (
    .entry(mem_rsp_data), .ea(ea_q), .page_size(rem_q), .phys(leaf_pa)
  );

  assign level_bad = (nb_q == '0) || (SIZE_W'(nb_q) > rem_q) ||
                     (lvl_q == LVL_W'(MAX_LEVELS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      ea_q    <= '0;
      guest_q <= 1'b0;
      base_q  <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      nb_q    <= '0;
      rem_q   <= '0;
      psize_q <= '0;
      lvl_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          ea_q    <= req_ea;
          guest_q <= req_guest;
          base_q  <= req_root_base;
          nb_q    <= req_root_bits;
          rem_q   <= req_tree_size;
          lvl_q   <= '0;
          pa_q    <= '0;
          psize_q <= '0;
          cause_q <= CAUSE_NONE;
          st_q    <= ST_LEVEL;
        end
        ST_LEVEL: begin
          if (level_bad) begin
            cause_q <= CAUSE_NO_ENTRY;
            st_q    <= ST_DONE;
          end else begin
            addr_q <= idx_addr;
            rem_q  <= rem_q - SIZE_W'(nb_q);
            lvl_q  <= lvl_q + LVL_W'(1);
            st_q   <= guest_q ? ST_NT_REQ : ST_MEM_REQ;
          end
        end
        ST_NT_REQ: if (nt_req_ready) st_q <= ST_NT_WAIT;
        ST_NT_WAIT: if (nt_rsp_valid) begin
          if (nt_rsp_fault) begin
            cause_q <= CAUSE_TABLE_XLATE;
            st_q    <= ST_DONE;
          end else begin
            addr_q <= nt_rsp_addr;
            st_q   <= ST_MEM_REQ;
          end
        end
        ST_MEM_REQ: if (mem_req_ready) st_q <= ST_MEM_WAIT;
        ST_MEM_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[ENT_VALID_BIT]) begin
            cause_q <= CAUSE_NO_ENTRY;
            st_q    <= ST_DONE;
          end else if (mem_rsp_data[ENT_LEAF_BIT]) begin
            pa_q    <= leaf_pa;
            psize_q <= rem_q;
            st_q    <= ST_DONE;
          end else begin
            base_q <= {mem_rsp_data[ADDR_W-1:ENT_BASE_LSB], {ENT_BASE_LSB{1'b0}}};
            nb_q   <= mem_rsp_data[ENT_NB_W-1:0];
            st_q   <= ST_LEVEL;
          end
        end
        ST_DONE: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign nt_req_valid  = (st_q == ST_NT_REQ);
  assign nt_req_addr   = addr_q;
  assign mem_req_valid = (st_q == ST_MEM_REQ);
  assign mem_req_addr  = addr_q;
  assign res_valid     = (st_q == ST_DONE);
  assign res_addr      = pa_q;
  assign res_page_size = psize_q;
  assign res_cause     = cause_q;

  // R2: hypervisor walks never use the second-stage port
  p_host_no_nested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nt_req_valid |-> guest_q);

  // R4: a nested fault goes straight to the result, with no memory read
  p_fault_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_req_valid == 1'b0 && st_q == ST_NT_WAIT && nt_rsp_valid && nt_rsp_fault)
      |=> (res_valid && !mem_req_valid && res_cause == 2'd2));

  // R9: never more levels than the limit
  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(MAX_LEVELS));

  // R10: request payloads held while stalled
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_nt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_req_valid && !nt_req_ready) |=> (nt_req_valid && $stable(nt_req_addr)));

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_cause)));

  p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && nt_req_valid) && !(req_ready && res_valid));
endmodule

// File: tb/radix_nested_walker_tb.sv
`timescale 1ns/1ps
module radix_nested_walker_tb_top;
  localparam int AW = 56;
  localparam int MAXL = 4;
  localparam logic [AW-1:0] ROOT = 56'h1000;
  localparam logic [AW-1:0] NT_OFF = 56'h800_0000_0000;
  localparam int TSIZE = 52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_guest = 1'b0;
  logic [63:0] req_ea = '0;
  logic [AW-1:0] req_root_base = '0;
  logic [4:0] req_root_bits = '0;
  logic [6:0] req_tree_size = '0;
  logic req_ready;
  logic nt_req_valid, mem_req_valid, res_valid;
  logic [AW-1:0] nt_req_addr, mem_req_addr, res_addr;
  logic [6:0] res_page_size;
  logic [1:0] res_cause;
  logic nt_req_ready = 1'b0, nt_rsp_valid = 1'b0, nt_rsp_fault = 1'b0;
  logic [AW-1:0] nt_rsp_addr = '0;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, res_ready = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  radix_nested_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea), .req_guest(req_guest),
    .req_root_base(req_root_base), .req_root_bits(req_root_bits), .req_tree_size(req_tree_size),
    .nt_req_valid(nt_req_valid), .nt_req_ready(nt_req_ready), .nt_req_addr(nt_req_addr),
    .nt_rsp_valid(nt_rsp_valid), .nt_rsp_addr(nt_rsp_addr), .nt_rsp_fault(nt_rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .res_page_size(res_page_size), .res_cause(res_cause)
  );

  int compared = 0, mismatched = 0;
  int launched = 0, results_seen = 0;
  bit run_chk = 0;
  logic [63:0] mem [logic [AW-1:0]];
  logic [AW-1:0] nt_fault_addr = '1;
  logic [AW-1:0] q_nt[$], q_mem[$];
  logic [AW-1:0] exp_addr;
  int exp_psize, exp_cause;
  string cur_tag = "";
  int lvl_nb [6] = '{13, 9, 9, 9, 4, 4};

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  // R1 entry address rule, computed from the requirement
  function automatic logic [AW-1:0] ent_addr(input logic [63:0] ea, input logic [AW-1:0] base,
                                             input int nb, input int rem);
    logic [63:0] idx;
    idx = (ea >> (rem - nb)) & ((64'd1 << nb) - 64'd1);
    return base + AW'(idx * 8);
  endfunction

  task automatic make_walk(input logic [63:0] ea, input logic guest, input int nlev,
                           input logic leaf_last, input logic [AW-1:0] rpn);
    logic [AW-1:0] base;
    int rem;
    base = ROOT;
    rem = TSIZE;
    for (int k = 0; k < nlev; k++) begin
      logic [AW-1:0] a, nxt;
      a = ent_addr(ea, base, lvl_nb[k], rem);
      nxt = 56'h20_0000 + AW'(k) * 56'h10_0000;
      rem -= lvl_nb[k];
      if (guest) a = a + NT_OFF;
      if (k == nlev - 1 && leaf_last) mem[a] = {2'b11, 6'd0, rpn[55:12], 12'h5A5};
      else mem[a] = {2'b10, 6'd0, nxt[55:8], 3'd0, 5'(lvl_nb[k+1])};
      base = nxt;
    end
  endtask

  // behavioural model of a walk
  task automatic build_expect(input logic [63:0] ea, input logic guest, input logic [AW-1:0] root,
                              input int nb0, input int size);
    logic [AW-1:0] base, a, msk;
    logic [63:0] e;
    int nb, rem, lvl;
    base = root; nb = nb0; rem = size; lvl = 0;
    exp_addr = '0; exp_psize = 0; exp_cause = 0;
    q_nt.delete(); q_mem.delete();
    forever begin
      if (nb == 0 || nb > rem || lvl == MAXL) begin exp_cause = 1; break; end
      a = ent_addr(ea, base, nb, rem);
      rem -= nb; lvl++;
      if (guest) begin
        q_nt.push_back(a);
        if (a == nt_fault_addr) begin exp_cause = 2; break; end
        a = a + NT_OFF;
      end
      q_mem.push_back(a);
      e = rd(a);
      if (!e[63]) begin exp_cause = 1; break; end
      if (e[62]) begin
        msk = (rem >= AW) ? '1 : ((AW'(1) << rem) - AW'(1));
        exp_addr = ({e[55:12], 12'd0} & ~msk) | (ea[AW-1:0] & msk);
        exp_psize = rem;
        break;
      end
      base = {e[55:8], 8'd0};
      nb = int'(e[4:0]);
    end
  endtask

  task automatic run_walk(input string tag, input logic [63:0] ea, input logic guest,
                          input int nb0, input int size);
    build_expect(ea, guest, ROOT, nb0, size);
    cur_tag = tag;
    @(posedge clk); #1;
    req_ea = ea; req_guest = guest; req_root_base = ROOT;
    req_root_bits = 5'(nb0); req_tree_size = 7'(size); req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    launched++;
    while (results_seen != launched) @(negedge clk);
  endtask

  // per-clock checker and responders (single process)
  initial begin
    logic [AW-1:0] mem_pend, nt_pend, pma, pna;
    int mem_cnt, nt_cnt;
    bit pmv, pnv, prv;
    mem_pend = '0; nt_pend = '0; pma = '0; pna = '0;
    mem_cnt = 0; nt_cnt = 0; pmv = 0; pnv = 0; prv = 0;
    forever begin
      @(negedge clk);
      if (run_chk) begin
        // R10 ready low while busy, held payloads
        cmp("R10 req_ready vs busy", 64'(req_ready), 64'(launched == results_seen));
        if (pmv) cmp("R10 mem hold", {8'd0, mem_req_valid ? mem_req_addr : ~pma}, {8'd0, pma});
        if (pnv) cmp("R10 nt hold", {8'd0, nt_req_valid ? nt_req_addr : ~pna}, {8'd0, pna});
        if (prv) cmp("R10 result hold", 64'(res_valid), 64'd1);
        if (nt_req_valid && nt_req_ready) begin
          if (q_nt.size() == 0) cmp({cur_tag, " R2 unexpected nested request"}, 64'(nt_req_addr), 64'hDEAD);
          else cmp({cur_tag, " R3 nested address"}, 64'(nt_req_addr), 64'(q_nt.pop_front()));
          nt_pend = nt_req_addr; nt_cnt = 1 + int'($urandom % 3);
        end
        if (mem_req_valid && mem_req_ready) begin
          if (q_mem.size() == 0) cmp({cur_tag, " R4 unexpected read"}, 64'(mem_req_addr), 64'hDEAD);
          else cmp({cur_tag, " R1 read address"}, 64'(mem_req_addr), 64'(q_mem.pop_front()));
          mem_pend = mem_req_addr; mem_cnt = 1 + int'($urandom % 3);
        end
        if (res_valid && res_ready) begin
          cmp({cur_tag, " cause"}, 64'(res_cause), 64'(exp_cause));
          cmp({cur_tag, " address"}, 64'(res_addr), 64'(exp_addr));
          cmp({cur_tag, " page size"}, 64'(res_page_size), 64'(exp_psize));
          cmp({cur_tag, " leftover fetches"}, 64'(q_mem.size() + q_nt.size()), 64'd0);
          results_seen++;
        end
        pmv = mem_req_valid && !mem_req_ready; pma = mem_req_addr;
        pnv = nt_req_valid && !nt_req_ready;   pna = nt_req_addr;
        prv = res_valid && !res_ready;
      end
      @(posedge clk); #1;
      mem_req_ready = ($urandom % 4) != 0;
      nt_req_ready  = ($urandom % 4) != 0;
      res_ready     = ($urandom % 3) != 0;
      mem_rsp_valid = 1'b0; nt_rsp_valid = 1'b0; nt_rsp_fault = 1'b0;
      if (mem_cnt > 0) begin   // R11 variable latency
        mem_cnt--;
        if (mem_cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd(mem_pend); end
      end
      if (nt_cnt > 0) begin
        nt_cnt--;
        if (nt_cnt == 0) begin
          nt_rsp_valid = 1'b1;
          nt_rsp_fault = (nt_pend == nt_fault_addr);
          nt_rsp_addr  = nt_pend + NT_OFF;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [63:0] ea;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    cmp("reset req_ready", 64'(req_ready), 64'd1);
    cmp("reset res_valid", 64'(res_valid), 64'd0);
    cmp("reset request valids", 64'({mem_req_valid, nt_req_valid}), 64'd0);
    run_chk = 1;

    ea = 64'h0000_1234_5678_9ABC;
    mem.delete(); make_walk(ea, 0, 4, 1, 56'hAB_CDEF_0000);
    run_walk("R1 R2 R5 R6 host four levels", ea, 0, 13, TSIZE);

    ea = 64'h000F_EDCB_A987_6543;
    mem.delete(); make_walk(ea, 0, 4, 1, 56'h12_3450_1000);
    run_walk("R5 R6 host second address", ea, 0, 13, TSIZE);

    mem.delete(); make_walk(ea, 1, 4, 1, 56'h77_0000_3000);
    run_walk("R3 guest four levels", ea, 1, 13, TSIZE);

    mem.delete(); make_walk(ea, 0, 2, 1, 56'h55_5555_5000);
    run_walk("R6 leaf at level two", ea, 0, 13, TSIZE);

    mem.delete(); make_walk(ea, 1, 2, 1, 56'h66_4000_0000);
    run_walk("R3 R6 guest large page", ea, 1, 13, TSIZE);

    mem.delete(); make_walk(ea, 1, 4, 1, 56'hAB_CDEF_0000);
    nt_fault_addr = ent_addr(ea, 56'h20_0000, 9, TSIZE - 13);
    run_walk("R4 nested fault level two", ea, 1, 13, TSIZE);
    nt_fault_addr = '1;

    mem.delete(); make_walk(ea, 0, 4, 1, 56'hAB_CDEF_0000);
    mem.delete(ent_addr(ea, 56'h30_0000, 9, TSIZE - 22));
    run_walk("R7 invalid entry level three", ea, 0, 13, TSIZE);

    mem.delete(); make_walk(ea, 0, 4, 1, 56'hAB_CDEF_0000);
    mem[ent_addr(ea, 56'h20_0000, 9, TSIZE - 13)] = {2'b10, 6'd0, 48'h4000, 3'd0, 5'd0};
    run_walk("R8 zero next width", ea, 0, 13, TSIZE);

    run_walk("R8 root width over size", ea, 0, 20, 16);

    mem.delete(); make_walk(ea, 0, 4, 0, '0);
    run_walk("R9 level limit host", ea, 0, 13, TSIZE);

    mem.delete(); make_walk(ea, 1, 4, 0, '0);
    run_walk("R9 level limit guest", ea, 1, 13, TSIZE);

    for (int i = 0; i < 6; i++) begin
      ea = {$urandom, $urandom};
      mem.delete(); make_walk(ea, 1'(i % 2), 4, 1, 56'h3C_0000_0000 + AW'(i) * 56'h1000);
      run_walk("R10 R11 back-to-back stalled", ea, 1'(i % 2), 13, TSIZE);
    end

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule